// File: doc/BRIEF.md
# Receiver Automatic Gain Controller

This block chooses the gain of a step-programmable amplifier and the reference voltage of a threshold comparator. It is meant for a very slow amplitude-keyed radio receiver. Digitized envelope samples arrive with a valid strobe. Over an observation window of `WIN_SEC` seconds at `CLK_HZ` clock cycles per second, the block records the largest and smallest accepted sample. When a window closes, one of two things happens. If the peak reached the target level, or the gain is already at its top step, the search stops. Otherwise the gain rises by one 10 dB step and a fresh window begins.

Once the search stops, the block freezes the gain and latches a comparator reference. The reference is computed from the last window's extremes with a formula that depends on the settled gain level. The block then raises a sync pulse for `SYNC_SEC` seconds. After the pulse ends it holds a done flag until the next start request. A start request restarts the search from level 0 in any state.

The controller runs through five states:

- **IDLE** is the state after reset. It waits for `start`.
- **OBSERVE** tracks the window extremes.
- **DECIDE** is a single cycle. From here the block either steps the gain up and goes back to OBSERVE, or settles and goes to SYNC.
- **SYNC** drives the sync pulse.
- **DONE** holds the result.

The transitions are:

- Any state goes to OBSERVE on `start`.
- IDLE goes to OBSERVE.
- OBSERVE goes to DECIDE when the window ends.
- DECIDE goes to OBSERVE on a step-up, or to SYNC on a settle.
- SYNC goes to DONE when the pulse length has elapsed.

Top module: `rx_gain_ctrl`

## Requirements
- R1: After reset, `gain_lvl` is 0, `gain_en` is all zero, and `cmp_ref`, `sync_o` and `done_o` are 0. These values stay unchanged until `start` is seen, even while samples arrive.
- R2: A window lasts `CLK_HZ*WIN_SEC` cycles of OBSERVE. Its maximum and minimum are taken over every sample presented with `smp_vld` high during those cycles.
- R3: When the window maximum is below `PEAK_TARGET` and the level is below `N_STEPS-1`, `gain_lvl` rises by exactly 1 and a new window starts. The level never changes by any other amount, except that it returns to 0 on start.
- R4: `gain_en` is a thermometer code of `gain_lvl`. Bit i is 1 exactly when `gain_lvl > i`, so bit 0 (the first amplifier stage) is enabled first.
- R5: At level `N_STEPS-1` the gain stops rising and the search settles, even if the peak never reached the target.
- R6: When settling at levels 0 to 3, `cmp_ref = min + floor((max-min)*21845/65536)`.
- R7: When settling at level 4, `cmp_ref = min + floor((max-min)*33095/65536)`.
- R8: When settling at level 5 or above, `cmp_ref = max - floor((max-min)*23592/65536)`.
- R9: After settling, `sync_o` is high for exactly `CLK_HZ*SYNC_SEC` cycles and then falls. `done_o` rises in the same cycle that `sync_o` falls, and the two are never high together. `cmp_ref` is steady while `sync_o` is high.
- R10: While `start` stays low, `done_o` remains high and the gain stays frozen. `start` in any state resets the level to 0, clears `cmp_ref` and `done_o`, and begins a new window.
- R11: A sample presented with `smp_vld` low affects neither extreme.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart the gain search from level 0 |
| smp_vld | input | 1 | Envelope sample strobe |
| smp | input | SMP_W | Envelope sample value |
| gain_en | output | N_STEPS | Amplifier step enables, thermometer coded |
| gain_lvl | output | LVL_W | Current gain level |
| cmp_ref | output | SMP_W | Comparator reference |
| sync_o | output | 1 | Sync pulse after settling |
| done_o | output | 1 | Search finished, held until start |

## Verification
The bench sweeps the target level so that the search settles at every level from 0 to 9. It also runs one case that never meets the target and must stop at level 9. Each settled level is checked against the formula for its band, so a design with the level 3/4 or 4/5 boundary in the wrong place produces a wrong reference. Every window contains an invalid sample carrying full scale or zero. A design that accepted those samples would settle at level 0 or report a floor of 0. The bench also checks the sync length, the done hold, and an abort in the middle of the search, which catches pulses off by one cycle and a restart that fails to clear the level.

// File: rtl/rx_gain_pkg.sv
package rx_gain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OBSERVE,
        ST_DECIDE,
        ST_SYNC,
        ST_DONE
    } agc_state_t;

    localparam int FRAC_BITS = 16;

    // Fixed-point scale factors in units of 1/65536, truncated
    localparam logic [FRAC_BITS-1:0] K_LOW   = 16'd21845; // one third
    localparam logic [FRAC_BITS-1:0] K_MID   = 16'd33095; // 0.505
    localparam logic [FRAC_BITS-1:0] K_UPPER = 16'd23592; // 0.36

    localparam int LVL_MID_BAND = 4;

endpackage

// File: rtl/rx_win_track.sv
module rx_win_track #(
    parameter int SMP_W   = 10,
    parameter int WIN_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp,
    output logic [SMP_W-1:0] peak,
    output logic [SMP_W-1:0] trough,
    output logic             win_last
);

    localparam int CNT_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [SMP_W-1:0] max_q;
    logic [SMP_W-1:0] min_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            max_q  <= '0;
            min_q  <= '1;
            seen_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            max_q  <= '0;
            min_q  <= '1;
            seen_q <= 1'b0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
            if (smp_vld) begin
                seen_q <= 1'b1;
                if (smp > max_q) max_q <= smp;
                if (smp < min_q) min_q <= smp;
            end
        end
    end

    assign peak     = max_q;
    assign trough   = seen_q ? min_q : max_q;
    assign win_last = run && (cnt_q == LAST_CNT);

endmodule

// File: rtl/rx_ref_calc.sv
module rx_ref_calc
    import rx_gain_pkg::*;
#(
    parameter int SMP_W = 10,
    parameter int LVL_W = 4
) (
    input  logic [SMP_W-1:0] peak,
    input  logic [SMP_W-1:0] trough,
    input  logic [LVL_W-1:0] lvl,
    output logic [SMP_W-1:0] ref_val
);

    localparam int PROD_W = SMP_W + FRAC_BITS;

    logic [SMP_W-1:0]      span;
    logic [FRAC_BITS-1:0]  k_sel;
    logic [PROD_W-1:0]     prod;
    logic [SMP_W-1:0]      part;
    logic                  from_top;

    always_comb begin
        span = peak - trough;
        if (lvl < LVL_W'(LVL_MID_BAND)) begin
            k_sel    = K_LOW;
            from_top = 1'b0;
        end else if (lvl == LVL_W'(LVL_MID_BAND)) begin
            k_sel    = K_MID;
            from_top = 1'b0;
        end else begin
            k_sel    = K_UPPER;
            from_top = 1'b1;
        end
        prod    = PROD_W'(span) * PROD_W'(k_sel);
        part    = prod[FRAC_BITS +: SMP_W];
        ref_val = from_top ? (peak - part) : (trough + part);
    end

endmodule

// File: rtl/rx_gain_map.sv
module rx_gain_map #(
    parameter int N_STEPS = 10,
    parameter int LVL_W   = 4
) (
    input  logic [LVL_W-1:0]   lvl,
    output logic [N_STEPS-1:0] en
);

    for (genvar i = 0; i < N_STEPS; i++) begin : g_step
        assign en[i] = (lvl > LVL_W'(i));
    end

endmodule

// File: rtl/rx_pulse_timer.sv
module rx_pulse_timer #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic last
);

    localparam int CNT_W = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (run)    cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && (cnt_q == LAST_CNT);

endmodule

// File: rtl/rx_gain_ctrl.sv
module rx_gain_ctrl
    import rx_gain_pkg::*;
#(
    parameter int SMP_W       = 10,
    parameter int N_STEPS     = 10,
    parameter int CLK_HZ      = 1000000,
    parameter int WIN_SEC     = 2,
    parameter int SYNC_SEC    = 2,
    parameter int PEAK_TARGET = 600,
    parameter int LVL_W       = $clog2(N_STEPS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               smp_vld,
    input  logic [SMP_W-1:0]   smp,
    output logic [N_STEPS-1:0] gain_en,
    output logic [LVL_W-1:0]   gain_lvl,
    output logic [SMP_W-1:0]   cmp_ref,
    output logic               sync_o,
    output logic               done_o
);

    localparam int WIN_LEN  = CLK_HZ * WIN_SEC;
    localparam int SYNC_LEN = CLK_HZ * SYNC_SEC;
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(N_STEPS - 1);
    localparam logic [SMP_W-1:0] TARGET  = SMP_W'(PEAK_TARGET);

    agc_state_t       state_q, state_d;
    logic [LVL_W-1:0] lvl_q;
    logic [SMP_W-1:0] ref_q;

    logic [SMP_W-1:0] win_peak, win_trough, ref_calc;
    logic             win_last, sync_last, settle;
    logic             trk_clr, trk_run, tmr_clr, tmr_run;

    // Window extremes
    rx_win_track #(.SMP_W(SMP_W), .WIN_LEN(WIN_LEN)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (trk_clr),
        .run      (trk_run),
        .smp_vld  (smp_vld),
        .smp      (smp),
        .peak     (win_peak),
        .trough   (win_trough),
        .win_last (win_last)
    );

    // Level-dependent reference
    rx_ref_calc #(.SMP_W(SMP_W), .LVL_W(LVL_W)) u_calc (
        .peak    (win_peak),
        .trough  (win_trough),
        .lvl     (lvl_q),
        .ref_val (ref_calc)
    );

    // Sync pulse length
    rx_pulse_timer #(.LEN(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .run   (tmr_run),
        .last  (sync_last)
    );

    rx_gain_map #(.N_STEPS(N_STEPS), .LVL_W(LVL_W)) u_map (
        .lvl (lvl_q),
        .en  (gain_en)
    );

    assign settle = (win_peak >= TARGET) || (lvl_q == TOP_LVL);

    // Next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_OBSERVE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_OBSERVE: if (win_last) state_d = ST_DECIDE;
                ST_DECIDE:  state_d = settle ? ST_SYNC : ST_OBSERVE;
                ST_SYNC:    if (sync_last) state_d = ST_DONE;
                ST_DONE:    state_d = ST_DONE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Level and reference registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            ref_q <= '0;
        end else if (start) begin
            lvl_q <= '0;
            ref_q <= '0;
        end else if (state_q == ST_DECIDE) begin
            if (settle) ref_q <= ref_calc;
            else        lvl_q <= lvl_q + 1'b1;
        end
    end

    // Outputs and sub-block controls
    always_comb begin
        trk_clr = start;
        trk_run = 1'b0;
        tmr_clr = 1'b0;
        tmr_run = 1'b0;
        sync_o  = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_OBSERVE: trk_run = 1'b1;
            ST_DECIDE: begin
                tmr_clr = 1'b1;
                if (!settle) trk_clr = 1'b1;
            end
            ST_SYNC: begin
                tmr_run = 1'b1;
                sync_o  = 1'b1;
            end
            ST_DONE:    done_o = 1'b1;
            default:    ;
        endcase
    end

    assign gain_lvl = lvl_q;
    assign cmp_ref  = ref_q;

endmodule

// File: rtl/rx_gain_ctrl_chk.sv
module rx_gain_ctrl_chk #(
    parameter int N_STEPS  = 10,
    parameter int LVL_W    = 4,
    parameter int SMP_W    = 10,
    parameter int SYNC_CYC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [LVL_W-1:0]   gain_lvl,
    input logic [N_STEPS-1:0] gain_en,
    input logic [SMP_W-1:0]   cmp_ref,
    input logic               sync_o,
    input logic               done_o
);

    int unsigned sync_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sync_run <= 0;
        else if (sync_o) sync_run <= sync_run + 1;
        else             sync_run <= 0;
    end

    assert_level_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_lvl) |-> (gain_lvl == $past(gain_lvl) + 1'b1) || (gain_lvl == '0));

    assert_level_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gain_lvl <= LVL_W'(N_STEPS - 1));

    assert_enable_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gain_en) == int'(gain_lvl));

    assert_sync_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_o && done_o));

    assert_sync_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> sync_run < SYNC_CYC);

    assert_ref_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && !start) |=> $stable(cmp_ref));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start) |=> done_o && $stable(gain_lvl));

    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (gain_lvl == '0) && !done_o && (cmp_ref == '0));

endmodule

bind rx_gain_ctrl rx_gain_ctrl_chk #(
    .N_STEPS  (N_STEPS),
    .LVL_W    (LVL_W),
    .SMP_W    (SMP_W),
    .SYNC_CYC (SYNC_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .gain_lvl (gain_lvl),
    .gain_en  (gain_en),
    .cmp_ref  (cmp_ref),
    .sync_o   (sync_o),
    .done_o   (done_o)
);

// File: tb/sim_rx_gain_ctrl.sv
module sim_rx_gain_ctrl;

    localparam int SMP_W    = 8;
    localparam int N_STEPS  = 10;
    localparam int CLK_HZ   = 4;
    localparam int WIN_SEC  = 2;
    localparam int SYNC_SEC = 2;
    localparam int TARGET   = 160;
    localparam int LVL_W    = 4;
    localparam int SYNC_LEN = CLK_HZ * SYNC_SEC;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               start;
    logic               smp_vld;
    logic [SMP_W-1:0]   smp;
    logic [N_STEPS-1:0] gain_en;
    logic [LVL_W-1:0]   gain_lvl;
    logic [SMP_W-1:0]   cmp_ref;
    logic               sync_o;
    logic               done_o;

    int n_chk = 0;
    int n_bad = 0;
    int k = 0;
    int wd = 0;

    always #10 clk = ~clk;

    rx_gain_ctrl #(
        .SMP_W(SMP_W), .N_STEPS(N_STEPS), .CLK_HZ(CLK_HZ),
        .WIN_SEC(WIN_SEC), .SYNC_SEC(SYNC_SEC), .PEAK_TARGET(TARGET), .LVL_W(LVL_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .smp_vld(smp_vld), .smp(smp),
        .gain_en(gain_en), .gain_lvl(gain_lvl), .cmp_ref(cmp_ref),
        .sync_o(sync_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 20000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    function automatic int exp_ref(input int mx, input int mn, input int lvl);
        int d = mx - mn;
        if (lvl <= 3)      return mn + ((d * 21845) >>> 16);
        else if (lvl == 4) return mn + ((d * 33095) >>> 16);
        else               return mx - ((d * 23592) >>> 16);
    endfunction

    // Envelope model: the peak reaches the target only once the gain is at tgt
    task automatic drive_sample(input int tgt);
        int lvl = int'(gain_lvl);
        int hi  = (lvl >= tgt) ? 200 + tgt : 100 + lvl;
        int lo  = 20 + 3 * tgt;
        int mid = (hi + lo) / 2;
        smp_vld = 1'b1;
        case (k % 4)
            0:       smp = SMP_W'(hi);
            2:       smp = SMP_W'(lo);
            default: smp = SMP_W'(mid);
        endcase
        if (k % 8 == 5) begin
            smp_vld = 1'b0;
            smp     = (k % 16 == 5) ? 8'hFF : 8'h00;
        end
        k++;
    endtask

    task automatic run_search(input int tgt, input int abort_after);
        int prev = 0;
        int steps = 0;
        bit bad_step = 0;
        int sync_len = 0;
        bit overlap = 0;
        bit done_seen = 0;
        int el = (tgt > 9) ? 9 : tgt;
        int mx = (tgt > 9) ? 109 : 200 + tgt;
        int mn = 20 + 3 * tgt;
        @(negedge clk);
        start = 1'b1;
        drive_sample(tgt);
        @(negedge clk);
        start = 1'b0;
        chk(gain_lvl == 0 && done_o == 0 && sync_o == 0 && cmp_ref == 0,
            "R10 restart clears", int'(gain_lvl) + int'(cmp_ref), 0);
        drive_sample(tgt);
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (abort_after > 0 && c == abort_after) begin
                chk(gain_lvl > 0, "R3 level rose before abort", int'(gain_lvl), 1);
                return;
            end
            if (int'(gain_lvl) != prev) begin
                steps++;
                if (int'(gain_lvl) != prev + 1) bad_step = 1;
                prev = int'(gain_lvl);
            end
            if (sync_o) begin
                sync_len++;
                if (done_o) overlap = 1;
            end
            if (done_o) begin
                done_seen = 1;
                break;
            end
            drive_sample(tgt);
        end
        chk(done_seen && !overlap, "R9 done follows sync", int'(done_seen), 1);
        chk(sync_len == SYNC_LEN, "R9 sync length", sync_len, SYNC_LEN);
        chk(int'(gain_lvl) == el, (tgt > 9) ? "R5 saturated level" : "R3 settled level",
            int'(gain_lvl), el);
        chk(steps == el && !bad_step, "R3 single steps", steps, el);
        chk(int'(gain_en) == (1 << el) - 1, "R4 thermometer enables", int'(gain_en), (1 << el) - 1);
        chk(int'(cmp_ref) == exp_ref(mx, mn, el),
            (el <= 3) ? "R6 R2 R11 reference" : (el == 4) ? "R7 R2 R11 reference" : "R8 R2 R11 reference",
            int'(cmp_ref), exp_ref(mx, mn, el));
        for (int h = 0; h < 12; h++) begin
            drive_sample(tgt);
            @(negedge clk);
        end
        chk(done_o && !sync_o && int'(gain_lvl) == el, "R10 done held", int'(done_o), 1);
    endtask

    initial begin
        rst_n   = 1'b0;
        start   = 1'b0;
        smp_vld = 1'b0;
        smp     = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            drive_sample(0);
            @(negedge clk);
        end
        chk(gain_lvl == 0, "R1 reset level", int'(gain_lvl), 0);
        chk(gain_en == 0, "R1 reset enables", int'(gain_en), 0);
        chk(cmp_ref == 0, "R1 reset reference", int'(cmp_ref), 0);
        chk(sync_o == 0, "R1 reset sync", int'(sync_o), 0);
        chk(done_o == 0, "R1 reset done", int'(done_o), 0);
        for (int t = 0; t <= 10; t++) run_search(t, 0);
        run_search(6, 30);
        run_search(4, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule